// File: doc/BRIEF.md
# Dual-Channel Selector and Magnitude Mixer

This block sits between a two-channel detector capture path and the spectral processing that follows it. Each valid input beat carries one 16-bit sample from the horizontal channel and one from the vertical channel, plus a flag that marks the first beat of a line. The block turns these pairs into a single 16-bit output stream with its own valid and line-start flags. A host register selects one of four modes: forward only the first channel, forward only the second, emit the vector magnitude of the pair, or emit both samples one after the other.

Magnitude mode computes the integer square root of the sum of the squared samples in a bit-per-stage pipeline. All other modes are delayed through the same pipeline, so the output order always matches the input order. In the two-sample mode each pair takes two output beats, and the block holds `inReady` low for the first cycle of each pair so that upstream keeps the pair in place. A new mode value is written into a pending register and takes over only on the next beat that carries the line-start flag. No line ever mixes two modes.

Top module: `pol_mixer`

## Requirements
- R1: After reset, `outValid` and `outSol` are 0, `inReady` is 1, and the active mode is channel 1 (encoding 2'b00) until a line starts under a different written mode.
- R2: In mode 2'b00 each accepted beat produces one output beat equal to `inCh1`, with `outSol` equal to that beat's `inSol`.
- R3: In mode 2'b01 each accepted beat produces one output beat equal to `inCh2`, with `outSol` equal to that beat's `inSol`.
- R4: In mode 2'b10 each accepted beat produces one output beat equal to floor(sqrt(inCh1² + inCh2²)). For example, 3 and 4 give 5.
- R5: In mode 2'b10, a magnitude larger than 65535 is output as 16'hFFFF.
- R6: In mode 2'b11 each pair produces two output beats, `inCh1` first and then `inCh2`. `inReady` is 0 during the first cycle the pair is presented and 1 during the second. Only the first of the two beats carries the pair's line-start flag.
- R7: A write with `cfgWe`=1 and `cfgAddr`=20 loads `cfgMode` as the pending mode. A write to any other address leaves the mode unchanged.
- R8: A pending mode applies starting with the next accepted beat whose `inSol` is 1. Beats of the current line keep the old mode, and the mode then holds until another write is followed by a line start.
- R9: Output beats appear in input order, with none dropped, duplicated or invented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Host register write strobe |
| cfgAddr | input | 8 | Host register address (mode register at 20) |
| cfgMode | input | 2 | Mode value: 00 ch1, 01 ch2, 10 magnitude, 11 interleaved |
| inValid | input | 1 | Input pair valid |
| inSol | input | 1 | Input pair is the first of a line |
| inCh1 | input | 16 | Channel 1 (horizontal) sample |
| inCh2 | input | 16 | Channel 2 (vertical) sample |
| inReady | output | 1 | Pair is consumed at this edge when high |
| outValid | output | 1 | Output sample valid |
| outSol | output | 1 | Output sample is the first of a line |
| outData | output | 16 | Output sample |

## Verification
Magnitude mode is driven with a Pythagorean pair, zero, one-sided full scale, non-square sums that test the floor, and pairs large enough to saturate. Together these separate a correct root from an off-by-one root, a missing clamp and a truncated sum. The selection modes use pairs in which the two channels differ, so a swapped channel shows up at once. The interleaved lines use distinct values for each beat, which exposes pair ordering, a stall placed on the wrong cycle, and a duplicated line-start flag. Writes to a wrong address and writes in the middle of a line, each followed by beats with and without a line start, confirm that a mode takes hold only at a line boundary.

// File: rtl/mixer_pkg.sv
package mixer_pkg;

  typedef enum logic [1:0] {
    MODE_CH1 = 2'b00,
    MODE_CH2 = 2'b01,
    MODE_MAG = 2'b10,
    MODE_ILV = 2'b11
  } mixMode_e;

  typedef enum logic [1:0] {
    PICK_CH1 = 2'b00,
    PICK_CH2 = 2'b01,
    PICK_MAG = 2'b10
  } pick_e;

  // Strobes from control to datapath, one per issued output beat
  typedef struct packed {
    logic  issue;
    logic  sol;
    pick_e pick;
  } mixStrobe_t;

endpackage

// File: rtl/mixer_isqrt.sv
module mixer_isqrt #(
  parameter int RAD_W  = 33,
  parameter int SIDE_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [RAD_W-1:0]  inRad,
  input  logic [SIDE_W-1:0] inSide,
  output logic              outValid,
  output logic [(RAD_W+1)/2-1:0] outRoot,
  output logic [SIDE_W-1:0] outSide
);
  localparam int ROOT_W = (RAD_W + 1) / 2;
  localparam int PAD_W  = 2 * ROOT_W;
  localparam int REM_W  = ROOT_W + 3;

  logic              vldQ  [0:ROOT_W];
  logic [PAD_W-1:0]  radQ  [0:ROOT_W];
  logic [REM_W-1:0]  remQ  [0:ROOT_W];
  logic [ROOT_W-1:0] rootQ [0:ROOT_W];
  logic [SIDE_W-1:0] sideQ [0:ROOT_W];

  // One result bit per stage: bring down two radicand bits, try root*4+1
  function automatic logic [REM_W+ROOT_W-1:0] sqStep(
    input logic [REM_W-1:0]  rem,
    input logic [ROOT_W-1:0] root,
    input logic [1:0]        pair
  );
    logic [REM_W-1:0] shifted;
    logic [REM_W-1:0] trial;
    shifted = {rem[REM_W-3:0], pair};
    trial   = REM_W'({root, 2'b01});
    if (shifted >= trial) return {shifted - trial, root[ROOT_W-2:0], 1'b1};
    else                  return {shifted, root[ROOT_W-2:0], 1'b0};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s <= ROOT_W; s++) begin
        vldQ[s]  <= 1'b0;
        radQ[s]  <= '0;
        remQ[s]  <= '0;
        rootQ[s] <= '0;
        sideQ[s] <= '0;
      end
    end else begin
      vldQ[0]  <= inValid;
      radQ[0]  <= PAD_W'(inRad);
      remQ[0]  <= '0;
      rootQ[0] <= '0;
      sideQ[0] <= inSide;
      for (int s = 0; s < ROOT_W; s++) begin
        vldQ[s+1]                <= vldQ[s];
        {remQ[s+1], rootQ[s+1]}  <= sqStep(remQ[s], rootQ[s], radQ[s][PAD_W-1 -: 2]);
        radQ[s+1]                <= radQ[s] << 2;
        sideQ[s+1]               <= sideQ[s];
      end
    end
  end

  assign outValid = vldQ[ROOT_W];
  assign outRoot  = rootQ[ROOT_W];
  assign outSide  = sideQ[ROOT_W];

  // R4
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    vldQ[ROOT_W] |-> (remQ[ROOT_W] <= REM_W'({rootQ[ROOT_W], 1'b0})));

endmodule

// File: rtl/mixer_ctrl.sv
module mixer_ctrl
  import mixer_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MODE_ADDR = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [1:0]        cfgMode,
  input  logic              inValid,
  input  logic              inSol,
  output logic              inReady,
  output mixStrobe_t        strobe
);
  mixMode_e pendMode, activeMode, effMode;
  logic     phase;
  logic     modeWrite;
  logic     solTake;

  assign modeWrite = cfgWe && (cfgAddr == ADDR_W'(MODE_ADDR));
  assign solTake   = inValid && inSol && !phase;
  assign effMode   = solTake ? pendMode : activeMode;
  // First cycle of an interleaved pair: keep the pair in place
  assign inReady   = !((effMode == MODE_ILV) && !phase);

  always_comb begin
    strobe.issue = inValid;
    strobe.sol   = solTake;
    unique case (effMode)
      MODE_CH2: strobe.pick = PICK_CH2;
      MODE_MAG: strobe.pick = PICK_MAG;
      MODE_ILV: strobe.pick = phase ? PICK_CH2 : PICK_CH1;
      default:  strobe.pick = PICK_CH1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMode   <= MODE_CH1;
      activeMode <= MODE_CH1;
      phase      <= 1'b0;
    end else begin
      if (modeWrite) pendMode <= mixMode_e'(cfgMode);
      if (solTake) activeMode <= pendMode;
      if (inValid && (effMode == MODE_ILV)) phase <= !phase;
    end
  end

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeWrite |=> $stable(pendMode));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !solTake |=> $stable(activeMode));

  // R6
  ilv_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inReady) |=> inReady);

endmodule

// File: rtl/mixer_datapath.sv
module mixer_datapath
  import mixer_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  mixStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] ch1,
  input  logic [SAMPLE_W-1:0] ch2,
  output logic                outValid,
  output logic                outSol,
  output logic [SAMPLE_W-1:0] outData
);
  localparam int RAD_W  = 2 * SAMPLE_W + 1;
  localparam int ROOT_W = (RAD_W + 1) / 2;
  localparam int SIDE_W = SAMPLE_W + 3;
  localparam logic [ROOT_W-1:0] ROOT_MAX = ROOT_W'({SAMPLE_W{1'b1}});

  logic [SAMPLE_W-1:0] sample;
  logic [RAD_W-1:0]    radicand;
  logic                rootVld;
  logic [ROOT_W-1:0]   rootVal;
  logic [SIDE_W-1:0]   sideOut;
  logic                sideSol;
  pick_e               sidePick;
  logic [SAMPLE_W-1:0] sideSample;
  logic [SAMPLE_W-1:0] magSat;

  assign sample   = (strobe.pick == PICK_CH2) ? ch2 : ch1;
  assign radicand = RAD_W'(ch1) * RAD_W'(ch1) + RAD_W'(ch2) * RAD_W'(ch2);

  mixer_isqrt #(
    .RAD_W (RAD_W),
    .SIDE_W(SIDE_W)
  ) isqrt_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (strobe.issue),
    .inRad   (radicand),
    .inSide  ({strobe.sol, strobe.pick, sample}),
    .outValid(rootVld),
    .outRoot (rootVal),
    .outSide (sideOut)
  );

  assign sideSol    = sideOut[SAMPLE_W+2];
  assign sidePick   = pick_e'(sideOut[SAMPLE_W+1:SAMPLE_W]);
  assign sideSample = sideOut[SAMPLE_W-1:0];
  assign magSat     = (rootVal > ROOT_MAX) ? {SAMPLE_W{1'b1}} : rootVal[SAMPLE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSol   <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= rootVld;
      outSol   <= rootVld && sideSol;
      outData  <= (sidePick == PICK_MAG) ? magSat : sideSample;
    end
  end

  // R2
  sol_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSol |-> outValid);

endmodule

// File: rtl/pol_mixer.sv
module pol_mixer
  import mixer_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int ADDR_W    = 8,
  parameter int MODE_ADDR = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [1:0]          cfgMode,
  input  logic                inValid,
  input  logic                inSol,
  input  logic [SAMPLE_W-1:0] inCh1,
  input  logic [SAMPLE_W-1:0] inCh2,
  output logic                inReady,
  output logic                outValid,
  output logic                outSol,
  output logic [SAMPLE_W-1:0] outData
);
  mixStrobe_t strobe;

  mixer_ctrl #(
    .ADDR_W   (ADDR_W),
    .MODE_ADDR(MODE_ADDR)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .cfgWe  (cfgWe),
    .cfgAddr(cfgAddr),
    .cfgMode(cfgMode),
    .inValid(inValid),
    .inSol  (inSol),
    .inReady(inReady),
    .strobe (strobe)
  );

  mixer_datapath #(
    .SAMPLE_W(SAMPLE_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ch1     (inCh1),
    .ch2     (inCh2),
    .outValid(outValid),
    .outSol  (outSol),
    .outData (outData)
  );

endmodule

// File: tb/pol_mixer_tb_top.sv
module pol_mixer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [1:0]  cfgMode = '0;
  logic        inValid = 1'b0;
  logic        inSol = 1'b0;
  logic [15:0] inCh1 = '0;
  logic [15:0] inCh2 = '0;
  logic        inReady;
  logic        outValid;
  logic        outSol;
  logic [15:0] outData;

  always #2 clk = ~clk;

  pol_mixer dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgMode(cfgMode),
    .inValid(inValid), .inSol(inSol), .inCh1(inCh1), .inCh2(inCh2), .inReady(inReady),
    .outValid(outValid), .outSol(outSol), .outData(outData)
  );

  typedef struct {
    logic [15:0] data;
    logic        sol;
    string       tag;
  } exp_t;

  exp_t   expQ[$];
  int     nChk = 0;
  int     nBad = 0;
  logic [1:0] pendM = 2'b00;
  logic [1:0] actM  = 2'b00;
  string  tagOvr = "";
  logic   done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint isq(input longint v);
    longint lo, hi, mid;
    lo = 0;
    hi = 200000;
    while (lo < hi) begin
      mid = (lo + hi + 1) / 2;
      if (mid * mid <= v) lo = mid;
      else hi = mid - 1;
    end
    return lo;
  endfunction

  function automatic void pushExp(input logic [15:0] d, input logic s, input string t);
    exp_t e;
    e.data = d;
    e.sol  = s;
    e.tag  = (tagOvr != "") ? tagOvr : t;
    expQ.push_back(e);
  endfunction

  task automatic cfgWrite(input logic [7:0] addr, input logic [1:0] mode);
    @(negedge clk);
    inValid = 1'b0;
    cfgWe   = 1'b1;
    cfgAddr = addr;
    cfgMode = mode;
    @(posedge clk);
    if (addr == 8'd20) pendM = mode;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    inSol   = 1'b0;
  endtask

  task automatic sendBeat(input logic [15:0] a, input logic [15:0] b, input logic s);
    logic [1:0] m;
    longint mag;
    bit rdy;
    m = s ? pendM : actM;
    if (s) actM = pendM;
    case (m)
      2'b00: pushExp(a, s, "R2");
      2'b01: pushExp(b, s, "R3");
      2'b10: begin
        mag = isq(longint'(a) * a + longint'(b) * b);
        if (mag > 65535) pushExp(16'hFFFF, s, "R5");
        else pushExp(mag[15:0], s, "R4");
      end
      default: begin
        pushExp(a, s, "R6");
        pushExp(b, 1'b0, "R6");
      end
    endcase
    @(negedge clk);
    inValid = 1'b1;
    inSol   = s;
    inCh1   = a;
    inCh2   = b;
    #1 rdy = inReady;
    if (m == 2'b11) begin
      // R6: first cycle of an interleaved pair is stalled
      chk(rdy == 1'b0, "R6", "inReady on first cycle of pair", rdy, 0);
      @(posedge clk);
      @(negedge clk);
      #1 rdy = inReady;
      chk(rdy == 1'b1, "R6", "inReady on second cycle of pair", rdy, 1);
      @(posedge clk);
    end else begin
      chk(rdy == 1'b1, "R9", "inReady in single-beat mode", rdy, 1);
      @(posedge clk);
    end
  endtask

  // Monitor: pop and compare in order
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R9", "unexpected output beat", outData, -1);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(outData == e.data, e.tag, "outData", outData, e.data);
        chk(outSol == e.sol, e.tag, "outSol", outSol, e.sol);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      nBad++;
      $display("FAIL R9: watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    chk(outSol == 1'b0, "R1", "outSol in reset", outSol, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    chk(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);

    // R1/R2: default mode is channel 1
    tagOvr = "R1";
    sendBeat(16'h1111, 16'h2222, 1'b1);
    sendBeat(16'hABCD, 16'h0F0F, 1'b0);
    tagOvr = "";
    sendBeat(16'h0000, 16'hFFFF, 1'b0);
    sendBeat(16'hFFFF, 16'h0000, 1'b0);
    idle();

    // R3
    cfgWrite(8'd20, 2'b01);
    sendBeat(16'h1234, 16'h5678, 1'b1);
    sendBeat(16'h9ABC, 16'hDEF0, 1'b0);
    idle();
    sendBeat(16'h0001, 16'h8000, 1'b0);
    idle();

    // R4 / R5
    cfgWrite(8'd20, 2'b10);
    sendBeat(16'd3, 16'd4, 1'b1);
    sendBeat(16'd0, 16'd0, 1'b0);
    sendBeat(16'd65535, 16'd0, 1'b0);
    sendBeat(16'd100, 16'd200, 1'b0);
    sendBeat(16'd12345, 16'd54321, 1'b0);
    sendBeat(16'd2, 16'd2, 1'b0);
    sendBeat(16'd65535, 16'd65535, 1'b0);
    sendBeat(16'd50000, 16'd50000, 1'b0);
    idle();

    // R6
    cfgWrite(8'd20, 2'b11);
    sendBeat(16'hA001, 16'hB001, 1'b1);
    sendBeat(16'hA002, 16'hB002, 1'b0);
    sendBeat(16'hA003, 16'hB003, 1'b0);
    idle();

    // R7: write to another address is ignored
    tagOvr = "R7";
    cfgWrite(8'd21, 2'b01);
    cfgWrite(8'd4, 2'b00);
    sendBeat(16'hC001, 16'hD001, 1'b1);
    sendBeat(16'hC002, 16'hD002, 1'b0);
    idle();

    // R8: mid-line write waits for the next line start
    tagOvr = "R8";
    cfgWrite(8'd20, 2'b00);
    sendBeat(16'hE001, 16'hF001, 1'b0);
    sendBeat(16'hE002, 16'hF002, 1'b0);
    sendBeat(16'hE003, 16'hF003, 1'b1);
    sendBeat(16'hE004, 16'hF004, 1'b0);
    cfgWrite(8'd20, 2'b10);
    sendBeat(16'd6, 16'd8, 1'b0);
    sendBeat(16'd6, 16'd8, 1'b1);
    sendBeat(16'd5, 16'd12, 1'b0);
    idle();
    tagOvr = "";

    // R9: everything drained, nothing extra
    repeat (40) @(negedge clk);
    chk(expQ.size() == 0, "R9", "pending expected beats", expQ.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule